// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block sits behind a serial-bus protocol engine in a byte-wide non-volatile memory. During a write transfer it gathers the incoming data bytes into a one-page holding buffer. The buffer holds 32 bytes, a valid flag for each byte, and the number of the page the bytes belong to. When the transfer ends, the block commits only the flagged bytes to the memory array through a plain write port. It then reports itself busy for a programmable erase/write interval. The block also owns the 11-bit address pointer. Writes step the pointer inside the current page. Reads step it across the whole array.

Data bytes arrive on a valid/ready stream. A byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` drops for the whole busy interval, so the protocol engine must hold a byte, or refuse it on the bus, until `wr_ready` returns. The pointer load, read step, end-of-transfer and protect pins are plain single-cycle controls. All of them are ignored while the block is busy.

Top module: `page_commit_seq`

## Requirements
- R1: After reset `busy` is 0, `wr_ready` is 1, `mem_we` is 0 and `cur_addr` is 0.
- R2: A cycle with `ptr_load` high and `busy` low sets `cur_addr` to {`ld_block`[2:0], `ld_word`[7:0]}, with the block bits as address bits 10:8. The load takes priority over any step in the same cycle.
- R3: Each data byte taken while `wp` is low is stored at the page offset `cur_addr`[4:0]. `cur_addr`[4:0] then advances by one and wraps from 31 to 0, while `cur_addr`[10:5] stays unchanged.
- R4: A cycle with `rd_step` high, `busy` low and no stored byte advances the full 11-bit `cur_addr` by one, wrapping from 2047 to 0.
- R5: When more than 32 bytes arrive in one transfer, a later byte at the same page offset replaces the earlier one. Only the last value at each offset is committed.
- R6: No array write happens before `xfer_end`. After it, the block writes each offset whose flag is set, in ascending offset order, at address {page, offset}. Array locations with no flagged byte keep their contents.
- R7: `busy` rises in the cycle after `xfer_end` and stays high for exactly PAGE_BYTES + EW_CYCLES cycles. During that time `wr_ready` is 0 and `ptr_load`, `rd_step`, `wr_valid` and `xfer_end` have no effect.
- R8: A byte taken while `wp` is high is discarded. It does not move the pointer and is never committed. A transfer made only of such bytes leaves `busy` low.
- R9: `xfer_end` with no stored byte, such as after an address-only transfer, does not raise `busy` and writes nothing.
- R10: After a commit, `cur_addr` keeps the value it had after the last stored byte.
- R11: `wr_ready` equals the inverse of `busy`, and a byte is consumed only in a cycle where `wr_valid` and `wr_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A data byte is offered |
| wr_ready | output | 1 | Block can take a byte (not busy) |
| wr_data | input | 8 | Offered data byte |
| ptr_load | input | 1 | Load the pointer from block and word fields |
| ld_block | input | 3 | Block select, becomes address bits 10:8 |
| ld_word | input | 8 | Word address, becomes address bits 7:0 |
| rd_step | input | 1 | A read byte was sent; advance the pointer |
| xfer_end | input | 1 | Transfer ended with STOP |
| wp | input | 1 | Write protect; data bytes discarded while high |
| busy | output | 1 | Commit or erase/write interval in progress |
| cur_addr | output | 11 | Current address pointer |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench sweeps every starting offset within a page and checks the pointer after each byte. A design that carried the page increment into bit 5 would show up as a wrong `cur_addr` at the 31-to-0 step. A design that wrapped reads inside a page would fail the 2047-to-0 walk. A 40-byte transfer checks that the second value at each repeated offset is the one that lands in the array. A design that appended data or wrote each byte straight through would leave the wrong bytes behind. Protected bytes, address-only transfers and pokes at the inputs during busy each have a fixed expected outcome: no busy, no array change, or an unchanged pointer. A design that ignored the protect pin, started empty commits, or let the pointer move while busy would break one of these. The full array is compared with a bench shadow after every transfer.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_COMMIT = 2'd1,
    SEQ_HOLD   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/page_buffer.sv
module page_buffer #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_off,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [PAGE_W-1:0] rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ROW_W-1:0]  row,
  output logic              any_valid
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_data [SLOTS];
  logic [SLOTS-1:0]  slot_flag;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        slot_flag[s] <= 1'b0;
      end else if (wr_en && wr_off == PAGE_W'(s)) begin
        slot_flag[s] <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_off == PAGE_W'(s)) slot_data[s] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     row <= '0;
    else if (wr_en) row <= wr_row;
  end

  assign rd_data   = slot_data[rd_off];
  assign rd_valid  = slot_flag[rd_off];
  assign any_valid = |slot_flag;
endmodule

// File: rtl/addr_pointer.sv
module addr_pointer #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5,
  parameter int BLK_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [BLK_W-1:0]        blk,
  input  logic [ADDR_W-BLK_W-1:0] word,
  input  logic                    page_step,
  input  logic                    full_step,
  output logic [ADDR_W-1:0]       ptr
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic [ROW_W-1:0]  row_part;
  logic [PAGE_W-1:0] off_part;
  assign row_part = ptr[ADDR_W-1:PAGE_W];
  assign off_part = ptr[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)         ptr <= '0;
    else if (load)      ptr <= {blk, word};
    else if (page_step) ptr <= {row_part, PAGE_W'(off_part + 1'b1)};
    else if (full_step) ptr <= ADDR_W'(ptr + 1'b1);
  end
endmodule

// File: rtl/commit_seq.sv
module commit_seq
  import page_commit_pkg::*;
#(
  parameter int PAGE_W    = 5,
  parameter int EW_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              slot_valid,
  output logic [PAGE_W-1:0] idx,
  output logic              we,
  output logic              busy,
  output logic              done
);
  localparam int TMR_W    = $clog2(EW_CYCLES + 1);
  localparam int LAST_IDX = (1 << PAGE_W) - 1;

  seq_state_t       state;
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      idx   <= '0;
      tmr   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (start) begin
          state <= SEQ_COMMIT;
          idx   <= '0;
        end
        SEQ_COMMIT: begin
          idx <= PAGE_W'(idx + 1'b1);
          if (idx == PAGE_W'(LAST_IDX)) begin
            state <= SEQ_HOLD;
            tmr   <= '0;
          end
        end
        SEQ_HOLD: begin
          tmr <= TMR_W'(tmr + 1'b1);
          if (tmr == TMR_W'(EW_CYCLES - 1)) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (state != SEQ_IDLE);
  assign we   = (state == SEQ_COMMIT) && slot_valid;
  assign done = (state == SEQ_HOLD) && (tmr == TMR_W'(EW_CYCLES - 1));
endmodule

// File: rtl/page_commit_seq.sv
module page_commit_seq #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 5,
  parameter int BLK_W     = 3,
  parameter int DATA_W    = 8,
  parameter int EW_CYCLES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    ptr_load,
  input  logic [BLK_W-1:0]        ld_block,
  input  logic [ADDR_W-BLK_W-1:0] ld_word,
  input  logic                    rd_step,
  input  logic                    xfer_end,
  input  logic                    wp,
  output logic                    busy,
  output logic [ADDR_W-1:0]       cur_addr,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic              take, store, do_load, do_rd, start;
  logic              seq_done, any_valid, slot_valid;
  logic [PAGE_W-1:0] seq_idx;
  logic [ROW_W-1:0]  buf_row;

  assign wr_ready = !busy;
  assign take     = wr_valid && wr_ready;
  assign store    = take && !wp;
  assign do_load  = ptr_load && !busy;
  assign do_rd    = rd_step && !busy && !store;
  assign start    = xfer_end && !busy && any_valid;

  addr_pointer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BLK_W(BLK_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(do_load), .blk(ld_block), .word(ld_word),
    .page_step(store), .full_step(do_rd), .ptr(cur_addr)
  );

  page_buffer #(.PAGE_W(PAGE_W), .DATA_W(DATA_W), .ROW_W(ROW_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(store),
    .wr_off(cur_addr[PAGE_W-1:0]), .wr_row(cur_addr[ADDR_W-1:PAGE_W]),
    .wr_data(wr_data), .clr(seq_done), .rd_off(seq_idx),
    .rd_data(mem_wdata), .rd_valid(slot_valid), .row(buf_row),
    .any_valid(any_valid)
  );

  commit_seq #(.PAGE_W(PAGE_W), .EW_CYCLES(EW_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .slot_valid(slot_valid),
    .idx(seq_idx), .we(mem_we), .busy(busy), .done(seq_done)
  );

  assign mem_addr = {buf_row, seq_idx};
endmodule

// File: rtl/page_commit_seq_chk.sv
module page_commit_seq_chk #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              ptr_load,
  input logic              rd_step,
  input logic              xfer_end,
  input logic              wp,
  input logic              busy,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              mem_we
);
  // R6: array writes only inside the commit window
  assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R9: busy can only start from an end-of-transfer
  assert_busy_from_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(xfer_end));

  // R3: stored byte steps only the in-page offset
  assert_page_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wp && !ptr_load) |=>
      (cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W])) &&
      (cur_addr[PAGE_W-1:0] == PAGE_W'($past(cur_addr[PAGE_W-1:0]) + 1'b1)));

  // R4: read step advances the full pointer
  assert_full_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && !busy && !ptr_load && !(wr_valid && !wp)) |=>
      cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

  // R8: protected byte leaves the pointer alone
  assert_wp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wp && !ptr_load && !rd_step) |=> $stable(cur_addr));

  // R7: pointer frozen while busy
  assert_busy_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_addr));

  // R11: no readiness during busy
  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);
endmodule

bind page_commit_seq page_commit_seq_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .ptr_load(ptr_load), .rd_step(rd_step), .xfer_end(xfer_end), .wp(wp),
  .busy(busy), .cur_addr(cur_addr), .mem_we(mem_we)
);

// File: tb/page_commit_seq_bench.sv
module page_commit_seq_bench;
  localparam int EW   = 20;
  localparam int PAGE = 32;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_valid = 0, ptr_load = 0, rd_step = 0, xfer_end = 0, wp = 0;
  logic [7:0]  wr_data = 0, ld_word = 0;
  logic [2:0]  ld_block = 0;
  logic        wr_ready, busy, mem_we;
  logic [10:0] cur_addr, mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0, errors = 0;
  logic [7:0]  arr [2048];
  logic [7:0]  shadow [2048];
  logic [7:0]  pend_d [PAGE];
  logic [PAGE-1:0] pend_v;
  logic [5:0]  pend_row;
  logic [10:0] eptr;
  int          wr_count;
  int          early_we;

  always #5 clk = ~clk;

  page_commit_seq #(.EW_CYCLES(EW)) u_page_commit_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .ptr_load(ptr_load), .ld_block(ld_block), .ld_word(ld_word),
    .rd_step(rd_step), .xfer_end(xfer_end), .wp(wp), .busy(busy),
    .cur_addr(cur_addr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) if (mem_we) begin
    arr[mem_addr] <= mem_wdata;
    wr_count <= wr_count + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] b, input logic [7:0] w);
    @(negedge clk); ptr_load = 1; ld_block = b; ld_word = w;
    @(negedge clk); ptr_load = 0;
    eptr = {b, w};
    chk(cur_addr == eptr, "R2 load", cur_addr, eptr);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    chk(wr_ready == 1'b1, "R11 ready when idle", wr_ready, 1);
    @(negedge clk); wr_valid = 0;
    if (!wp) begin
      pend_d[eptr[4:0]] = d; pend_v[eptr[4:0]] = 1'b1; pend_row = eptr[10:5];
      eptr = {eptr[10:5], 5'(eptr[4:0] + 1)};
      chk(cur_addr == eptr, "R3 in-page step", cur_addr, eptr);
    end else begin
      chk(cur_addr == eptr, "R8 protected byte keeps pointer", cur_addr, eptr);
    end
    chk(wr_count == 0 && !busy, "R6 no write before end", wr_count, 0);
  endtask

  task automatic finish_xfer(input bit poke);
    int n; int nexp; bit expect_busy;
    expect_busy = |pend_v;
    nexp = 0;
    for (int i = 0; i < PAGE; i++) if (pend_v[i]) begin
      shadow[{pend_row, 5'(i)}] = pend_d[i]; nexp++;
    end
    @(negedge clk); xfer_end = 1;
    @(negedge clk); xfer_end = 0;
    n = 0;
    if (poke && busy) begin
      ptr_load = 1; ld_block = 3'd6; ld_word = 8'h11; wr_valid = 1; rd_step = 1; xfer_end = 1;
      @(negedge clk); ptr_load = 0; wr_valid = 0; rd_step = 0; xfer_end = 0; n = 1;
      chk(cur_addr == eptr && !wr_ready, "R7 inputs ignored while busy", cur_addr, eptr);
    end
    while (busy && n < 1000) begin n++; @(negedge clk); end
    if (expect_busy)
      chk(n == PAGE + EW, "R7 busy length", n, PAGE + EW);
    else
      chk(n == 0, "R9 no busy without data", n, 0);
    chk(wr_count == nexp, "R6 write count", wr_count, nexp);
    begin
      int bad; bad = 0;
      for (int a = 0; a < 2048; a++) if (arr[a] !== shadow[a]) bad++;
      chk(bad == 0, "R6 array contents", bad, 0);
    end
    chk(cur_addr == eptr, "R10 pointer kept after commit", cur_addr, eptr);
    pend_v = '0; wr_count = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 2048; a++) begin arr[a] = 8'(a * 7 + 3); shadow[a] = 8'(a * 7 + 3); end
    pend_v = '0; wr_count = 0; eptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && wr_ready && !mem_we && cur_addr == 0, "R1 reset state", cur_addr, 0);

    // R3 wrap inside page, R10 after commit
    load(3'd3, 8'h1C);
    for (int i = 0; i < 6; i++) send(8'h40 + 8'(i));
    finish_xfer(1'b0);

    // R5 overflow: 40 bytes
    load(3'd5, 8'h20);
    for (int i = 0; i < 40; i++) send(8'h80 + 8'(i));
    finish_xfer(1'b0);

    // R4 full wrap on reads
    load(3'd7, 8'hFE);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rd_step = 1;
      @(negedge clk); rd_step = 0;
      eptr = 11'(eptr + 1);
      chk(cur_addr == eptr, "R4 read step wrap", cur_addr, eptr);
    end

    // R8 protected transfer
    load(3'd1, 8'h05);
    wp = 1;
    for (int i = 0; i < 3; i++) send(8'hEE);
    finish_xfer(1'b0);
    wp = 0;

    // R9 address-only transfer
    load(3'd2, 8'h33);
    finish_xfer(1'b0);

    // R7 pokes during busy
    load(3'd4, 8'h3E);
    send(8'h5A); send(8'hA5);
    finish_xfer(1'b1);

    // sweep every start offset
    for (int off = 0; off < 32; off++) begin
      load(3'(off % 8), 8'(off * 9));
      for (int k = 0; k <= off % 7; k++) send(8'(off * 13 + k));
      finish_xfer(1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule